// File: doc/BRIEF.md
# Pipelined Multiply-Add with Wide Addend

This block forms a 64-bit result from three operands. It multiplies a 19-bit port by an 18-bit port, then adds a 36-bit addend to that product, or takes the addend away from it. In signed mode all three operands are two's complement and every bit of the 19-bit port is used. In unsigned mode the operands are plain binary, both multiplier operands are 18 bits wide, and the top bit of the 19-bit port has no effect.

Every sample carries its own add/subtract choice and a valid flag. Both travel with the operands through four register stages: an input bank, a product stage, a sum stage and an output bank. A single clock enable stalls all stages together. A synchronous clear empties the pipeline. The signed/unsigned selection is static. The block takes it in only while no sample is in flight, so the selection cannot change a sample that has already been accepted.

Top module: `madd_wide`

## Requirements
- R1: With mode_signed=1, result equals the sign-extended 19-bit mul_a times the sign-extended 18-bit mul_b, plus the sign-extended 36-bit addend, taken modulo 2^64.
- R2: With mode_signed=0, result equals mul_a[17:0] times mul_b, both zero-extended, plus the zero-extended addend, modulo 2^64; mul_a[18] has no effect on result.
- R3: op_sub=1 selects product minus addend (never addend minus product); op_sub=0 selects product plus addend.
- R4: A sample accepted on an enabled edge (ce=1, in_valid=1) appears on result with out_valid=1 after exactly three further enabled edges, i.e. on the fourth enabled edge counting the capture edge; out_valid is 0 for cycles carrying no accepted sample.
- R5: On an edge with ce=0 and clr=0, no stage changes: result and out_valid hold, and no accepted sample is lost or duplicated.
- R6: clr=1 on a clock edge, whatever ce is, drives result to 0 and out_valid to 0 after that edge, and discards every sample in flight.
- R7: While rst_n=0 on clock edges, result reads 0 and out_valid reads 0.
- R8: mode_signed is taken into account only on edges where no accepted sample is in the input, product or sum stage; a change of mode_signed while samples are in flight does not alter those samples.
- R9: Back-to-back samples with alternating op_sub each use their own op_sub value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Clock enable for all stages |
| clr | input | 1 | Synchronous clear of all stages |
| mode_signed | input | 1 | 1 = two's complement, 0 = unsigned |
| in_valid | input | 1 | Sample present on the operand ports |
| op_sub | input | 1 | 1 = product minus addend, 0 = product plus addend |
| mul_a | input | 19 | Multiplicand (18 low bits used in unsigned mode) |
| mul_b | input | 18 | Multiplier |
| addend | input | 36 | Wide addend |
| result | output | 64 | Arithmetic result |
| out_valid | output | 1 | result holds a completed sample |

## Verification
The assertions assume that mode_signed is moved only when the pipeline is empty, except in the one deliberate R8 case, where it is held steady at each capture edge. They also assume that rst_n and clr are driven synchronously. The stimulus changes all inputs on the falling edge. Before a mode change the bench drains the pipeline with idle cycles. In the mode-hold scenario it moves mode_signed only while the accepted sample sits in the internal stages, and it restores the value before the pipeline empties. The reference model is a 64-bit computation in the bench. It counts enabled edges to place each expected value, so the bench tracks the sample timing correctly while the clock enable toggles.

// File: rtl/madd_pkg.sv
// Package: shared widths and the per-sample operation type of the
// multiply-add pipeline. Assumes the 19/18/36/64 split as default.
package madd_pkg;
    localparam int unsigned DEF_A_W = 19;
    localparam int unsigned DEF_B_W = 18;
    localparam int unsigned DEF_C_W = 36;
    localparam int unsigned DEF_R_W = 64;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;
endpackage

// File: rtl/madd_in_stage.sv
// Input register bank: captures the operands, the operation and the valid flag.
// Assumes rst_n and clr are synchronous; clr wins over ce.
module madd_in_stage
    import madd_pkg::*;
#(
    parameter int unsigned A_W = DEF_A_W,
    parameter int unsigned B_W = DEF_B_W,
    parameter int unsigned C_W = DEF_C_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce,
    input  logic           clr,
    input  logic           in_valid,
    input  op_e            op_in,
    input  logic [A_W-1:0] a_in,
    input  logic [B_W-1:0] b_in,
    input  logic [C_W-1:0] c_in,
    output logic           v_q,
    output op_e            op_q,
    output logic [A_W-1:0] a_q,
    output logic [B_W-1:0] b_q,
    output logic [C_W-1:0] c_q
);
    // Capture a new sample on each enabled edge; clear empties the bank.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            v_q  <= 1'b0;
            op_q <= OP_ADD;
            a_q  <= '0;
            b_q  <= '0;
            c_q  <= '0;
        end else if (ce) begin
            v_q  <= in_valid;
            op_q <= op_in;
            a_q  <= a_in;
            b_q  <= b_in;
            c_q  <= c_in;
        end
    end

    // A clear empties the bank on the following cycle.
    assert_in_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !v_q);
endmodule

// File: rtl/madd_mul_stage.sv
// First pipeline stage: extends the operands per mode and registers their product.
// Assumes mode is stable while a sample is in this stage.
module madd_mul_stage
    import madd_pkg::*;
#(
    parameter int unsigned A_W = DEF_A_W,
    parameter int unsigned B_W = DEF_B_W,
    parameter int unsigned C_W = DEF_C_W,
    localparam int unsigned PW = A_W + B_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce,
    input  logic                 clr,
    input  logic                 mode_signed,
    input  logic                 v_in,
    input  op_e                  op_in,
    input  logic [A_W-1:0]       a_in,
    input  logic [B_W-1:0]       b_in,
    input  logic [C_W-1:0]       c_in,
    output logic                 v_q,
    output op_e                  op_q,
    output logic signed [PW-1:0] prod_q,
    output logic [C_W-1:0]       c_q
);
    logic signed [A_W:0]  a_x;
    logic signed [B_W:0]  b_x;
    logic signed [PW-1:0] prod_d;

    // Extend operands: sign bit in signed mode, zeros (top a bit dropped) otherwise.
    always_comb begin
        if (mode_signed) begin
            a_x = $signed({a_in[A_W-1], a_in});
            b_x = $signed({b_in[B_W-1], b_in});
        end else begin
            a_x = $signed({2'b00, a_in[A_W-2:0]});
            b_x = $signed({1'b0, b_in});
        end
        prod_d = a_x * b_x;
    end

    // Register the product and carry the addend and controls along.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            v_q    <= 1'b0;
            op_q   <= OP_ADD;
            prod_q <= '0;
            c_q    <= '0;
        end else if (ce) begin
            v_q    <= v_in;
            op_q   <= op_in;
            prod_q <= prod_d;
            c_q    <= c_in;
        end
    end

    // An unsigned product of two (A_W-1)-bit values never reaches the top bits.
    assert_unsigned_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && !mode_signed) |-> (prod_q[PW-1:2*(A_W-1)] == '0));
endmodule

// File: rtl/madd_acc_stage.sv
// Second pipeline stage: extends product and addend to the result width and
// adds or subtracts (product minus addend). Assumes mode is stable meanwhile.
module madd_acc_stage
    import madd_pkg::*;
#(
    parameter int unsigned PW  = DEF_A_W + DEF_B_W + 2,
    parameter int unsigned C_W = DEF_C_W,
    parameter int unsigned R_W = DEF_R_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce,
    input  logic                 clr,
    input  logic                 mode_signed,
    input  logic                 v_in,
    input  op_e                  op_in,
    input  logic signed [PW-1:0] prod_in,
    input  logic [C_W-1:0]       c_in,
    output logic                 v_q,
    output logic [R_W-1:0]       sum_q
);
    logic [R_W-1:0] p_ext;
    logic [R_W-1:0] c_ext;
    logic [R_W-1:0] sum_d;

    // Widen both terms and form the sum or difference.
    always_comb begin
        p_ext = {{(R_W-PW){prod_in[PW-1]}}, prod_in};
        c_ext = {{(R_W-C_W){mode_signed & c_in[C_W-1]}}, c_in};
        sum_d = (op_in == OP_SUB) ? (p_ext - c_ext) : (p_ext + c_ext);
    end

    // Register the sum and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            v_q   <= 1'b0;
            sum_q <= '0;
        end else if (ce) begin
            v_q   <= v_in;
            sum_q <= sum_d;
        end
    end
endmodule

// File: rtl/madd_out_stage.sv
// Output register bank: presents the finished result and its valid flag.
// Assumes rst_n and clr are synchronous; clr wins over ce.
module madd_out_stage #(
    parameter int unsigned R_W = madd_pkg::DEF_R_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce,
    input  logic           clr,
    input  logic           v_in,
    input  logic [R_W-1:0] sum_in,
    output logic           out_valid,
    output logic [R_W-1:0] result
);
    // Load the output bank on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else if (ce) begin
            out_valid <= v_in;
            result    <= sum_in;
        end
    end

    // With the enable low and no clear, the outputs hold.
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !clr) |=> ($stable(result) && $stable(out_valid)));

    // After a clear the outputs read zero.
    assert_out_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!out_valid && result == '0));
endmodule

// File: rtl/madd_wide.sv
// Top: four-stage multiply-add with a wide addend and signed/unsigned mode.
// Holds the mode in a register that reloads only while the pipeline is empty.
// Assumes mode_signed changes only while idle.
module madd_wide
    import madd_pkg::*;
#(
    parameter int unsigned A_W = DEF_A_W,
    parameter int unsigned B_W = DEF_B_W,
    parameter int unsigned C_W = DEF_C_W,
    parameter int unsigned R_W = DEF_R_W,
    localparam int unsigned PW = A_W + B_W + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce,
    input  logic           clr,
    input  logic           mode_signed,
    input  logic           in_valid,
    input  logic           op_sub,
    input  logic [A_W-1:0] mul_a,
    input  logic [B_W-1:0] mul_b,
    input  logic [C_W-1:0] addend,
    output logic [R_W-1:0] result,
    output logic           out_valid
);
    logic                 mode_q;
    logic                 busy;
    op_e                  op_in;
    logic                 s0_v, s1_v, s2_v;
    op_e                  s0_op, s1_op;
    logic [A_W-1:0]       s0_a;
    logic [B_W-1:0]       s0_b;
    logic [C_W-1:0]       s0_c, s1_c;
    logic signed [PW-1:0] s1_p;
    logic [R_W-1:0]       s2_sum;

    assign op_in = op_e'(op_sub);
    assign busy  = s0_v | s1_v | s2_v;

    // Reload the mode only when no sample is inside the arithmetic stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else if (!busy) begin
            mode_q <= mode_signed;
        end
    end

    madd_in_stage #(.A_W(A_W), .B_W(B_W), .C_W(C_W)) u_in (
        .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr),
        .in_valid(in_valid), .op_in(op_in),
        .a_in(mul_a), .b_in(mul_b), .c_in(addend),
        .v_q(s0_v), .op_q(s0_op), .a_q(s0_a), .b_q(s0_b), .c_q(s0_c)
    );

    madd_mul_stage #(.A_W(A_W), .B_W(B_W), .C_W(C_W)) u_mul (
        .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr), .mode_signed(mode_q),
        .v_in(s0_v), .op_in(s0_op), .a_in(s0_a), .b_in(s0_b), .c_in(s0_c),
        .v_q(s1_v), .op_q(s1_op), .prod_q(s1_p), .c_q(s1_c)
    );

    madd_acc_stage #(.PW(PW), .C_W(C_W), .R_W(R_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr), .mode_signed(mode_q),
        .v_in(s1_v), .op_in(s1_op), .prod_in(s1_p), .c_in(s1_c),
        .v_q(s2_v), .sum_q(s2_sum)
    );

    madd_out_stage #(.R_W(R_W)) u_out (
        .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr),
        .v_in(s2_v), .sum_in(s2_sum),
        .out_valid(out_valid), .result(result)
    );

    // The mode register holds while any sample is in flight.
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_q));

    // A valid sum leaves through the output bank on the next enabled edge.
    assert_valid_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !clr && s2_v) |=> out_valid);
endmodule

// File: tb/tb_madd_wide.sv
module tb_madd_wide;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic        clr = 1'b0;
    logic        mode_signed = 1'b1;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [18:0] mul_a = '0;
    logic [17:0] mul_b = '0;
    logic [35:0] addend = '0;
    logic [63:0] result;
    logic        out_valid;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string tag_cur = "R1";

    logic [63:0] exp_q[$];
    int          cnt_q[$];
    string       tag_q[$];
    int          en_cnt = 0;
    logic        ce_seen = 1'b0;
    logic        clr_seen = 1'b1;
    logic [63:0] prev_res = '0;
    logic        prev_v = 1'b0;

    madd_wide dut (
        .clk(clk), .rst_n(rst_n), .ce(ce), .clr(clr), .mode_signed(mode_signed),
        .in_valid(in_valid), .op_sub(op_sub), .mul_a(mul_a), .mul_b(mul_b),
        .addend(addend), .result(result), .out_valid(out_valid)
    );

    always #5 clk = ~clk;

    function automatic logic [63:0] model(bit sgn, bit sb, logic [18:0] a,
                                          logic [17:0] b, logic [35:0] c);
        logic [63:0] pa, pb, p, cc;
        if (sgn) begin
            pa = {{45{a[18]}}, a};
            pb = {{46{b[17]}}, b};
            cc = {{28{c[35]}}, c};
        end else begin
            pa = {46'b0, a[17:0]};
            pb = {46'b0, b};
            cc = {28'b0, c};
        end
        p = pa * pb;
        return sb ? (p - cc) : (p + cc);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference pipeline: record each accepted sample with its enabled-edge index.
    always @(posedge clk) begin
        ce_seen  <= ce;
        clr_seen <= clr || !rst_n;
        if (!rst_n || clr) begin
            exp_q.delete();
            cnt_q.delete();
            tag_q.delete();
        end else if (ce) begin
            en_cnt = en_cnt + 1;
            if (in_valid) begin
                exp_q.push_back(model(mode_signed, op_sub, mul_a, mul_b, addend));
                cnt_q.push_back(en_cnt);
                tag_q.push_back(tag_cur);
            end
        end
    end

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !clr_seen) begin
            if (ce_seen) begin
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check("R4 unexpected out_valid", 64'd1, 64'd0);
                    end else begin
                        string t;
                        logic [63:0] e;
                        int c0;
                        t  = tag_q.pop_front();
                        e  = exp_q.pop_front();
                        c0 = cnt_q.pop_front();
                        check(t, result, e);
                        check({"R4 latency ", t}, 64'(en_cnt - c0), 64'd3);
                    end
                end
            end else begin
                check("R5 result held", result, prev_res);
                check("R5 valid held", 64'(out_valid), 64'(prev_v));
            end
        end
        prev_res = result;
        prev_v   = out_valid;
    end

    task automatic drive(bit v, bit s, logic [18:0] a, logic [17:0] b,
                         logic [35:0] c, bit en);
        @(negedge clk);
        in_valid = v; op_sub = s; mul_a = a; mul_b = b; addend = c; ce = en;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0, '0, '0, 1'b1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 result in reset", result, 64'd0);
        check("R7 out_valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        idle(2);
    endtask

    task automatic t_signed();
        tag_cur = "R1 signed";
        mode_signed = 1'b1;
        idle(4);
        drive(1, 0, 19'd5, 18'd7, 36'd100, 1);
        drive(1, 0, 19'h7FFFD, 18'd4, 36'hFFFFFFFF6, 1);
        drive(1, 0, 19'h3FFFF, 18'h1FFFF, 36'h7FFFFFFFF, 1);
        drive(1, 0, 19'h12345, 18'h2ABCD, 36'h123456789, 1);
        idle(6);
    endtask

    task automatic t_unsigned();
        mode_signed = 1'b0;
        idle(4);
        tag_cur = "R2 unsigned";
        drive(1, 0, 19'h7FFFF, 18'h3FFFF, 36'hFFFFFFFFF, 1);
        drive(1, 0, 19'h3FFFF, 18'h3FFFF, 36'hFFFFFFFFF, 1);
        drive(1, 0, 19'h40001, 18'd3, 36'd9, 1);
        drive(1, 0, 19'h00001, 18'd3, 36'd9, 1);
        idle(6);
    endtask

    task automatic t_sub();
        tag_cur = "R3 subtract unsigned";
        drive(1, 1, 19'd2, 18'd3, 36'd10, 1);
        drive(1, 1, 19'd0, 18'd0, 36'hFFFFFFFFF, 1);
        idle(6);
        mode_signed = 1'b1;
        idle(4);
        tag_cur = "R3 subtract signed";
        drive(1, 1, 19'd2, 18'd3, 36'd10, 1);
        drive(1, 1, 19'h7FFFF, 18'd1, 36'hFFFFFFFFF, 1);
        idle(6);
    endtask

    task automatic t_extremes();
        tag_cur = "R1 R3 extremes";
        drive(1, 1, 19'h40000, 18'h20000, 36'h800000000, 1);
        drive(1, 0, 19'h40000, 18'h20000, 36'h800000000, 1);
        drive(1, 0, 19'h40000, 18'h1FFFF, 36'h800000000, 1);
        drive(1, 1, 19'h3FFFF, 18'h20000, 36'h7FFFFFFFF, 1);
        idle(6);
    endtask

    task automatic t_b2b_ce();
        tag_cur = "R9 R5 back-to-back";
        for (int i = 0; i < 12; i++) begin
            drive(1, i[0], 19'(i * 4099 + 19'h40000), 18'(i * 777 + 5),
                  36'(i * 64'h1_2345_6789), (i % 3) != 2);
        end
        for (int i = 0; i < 5; i++) drive(1, 1, 19'h11111, 18'h22222, 36'h5, 0);
        idle(8);
    endtask

    task automatic t_clear();
        tag_cur = "R6 pre-clear";
        drive(1, 0, 19'd1, 18'd1, 36'd1, 1);
        drive(1, 1, 19'd2, 18'd2, 36'd2, 1);
        drive(1, 0, 19'd3, 18'd3, 36'd3, 1);
        drive(1, 0, 19'd4, 18'd4, 36'd4, 1);
        @(negedge clk);
        clr = 1'b1; in_valid = 1'b0; ce = 1'b0;
        @(negedge clk);
        check("R6 result after clear", result, 64'd0);
        check("R6 out_valid after clear", 64'(out_valid), 64'd0);
        clr = 1'b0;
        idle(6);
    endtask

    task automatic t_mode();
        tag_cur = "R8 mode held in flight";
        mode_signed = 1'b1;
        idle(4);
        drive(1, 0, 19'h7FFFF, 18'h3FFFF, 36'hFFFFFFFFF, 1);
        @(negedge clk);
        in_valid = 1'b0; mode_signed = 1'b0;
        @(negedge clk);
        mode_signed = 1'b1;
        idle(6);
    endtask

    initial begin
        t_reset();
        t_signed();
        t_unsigned();
        t_sub();
        t_extremes();
        t_b2b_ce();
        t_clear();
        t_mode();
        check("R4 all samples delivered", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule